// File: doc/BRIEF.md
# Scrambling Extended RAM Controller

This block holds 256 bytes of general-purpose storage that the CPU reaches through a larger address window. The enclosing decoder passes only the low eight offset bits, so every 256-byte slice of the window lands on the same cells. A 12-bit mode word, driven from elsewhere, changes how each access treats its address and data. Reads can flip the top address bit. Writes can rotate the address and pin either nibble of the data to all zeros or all ones.

A read can also schedule an automatic write-back into the cell it just read. The value written back can be zero, all ones, the cell's own address, or the previously read byte, and the AND of these when several are enabled. A hidden last-read register keeps the most recent read byte unless the mode word freezes it. A separate mode bit requests an IRQ-latch clear whenever the CPU stores a zero byte anywhere in the storage.

Top module: `exram_scrambler`

## Requirements
- R1: After reset, `rd_data` and `irq_clr` are 0 and the hidden last-read byte is 0x00.
- R2: A read (`rd_en` high, `wr_en` low) returns the cell's byte on `rd_data` after the next rising edge, and `rd_data` then holds until the next read. When `rd_en` and `wr_en` are both high, the write is performed and the read is ignored.
- R3: With `mode[0]` set, a read uses the address with bit 7 inverted. Writes ignore `mode[0]`.
- R4: With `mode[1]` set, a write stores to the address rotated left by two bits ({a[5:0], a[7:6]}). Reads ignore `mode[1]`.
- R5: On writes, `mode[2]` forces data bits [3:0] to 0x0 and `mode[3]` forces them to 0xF. `mode[4]` forces bits [7:4] to 0x0 and `mode[5]` forces them to 0xF. If both forces on one nibble are set, that nibble becomes 0x0.
- R6: A read with `mode[6]` set writes 0x00 into the cell just read, and a read with `mode[7]` set writes 0xFF there. The write-back happens on the clock edge after the one that returned the read data.
- R7: A read with `mode[8]` set writes the cell's own (effective) address into that cell.
- R8: A read with `mode[9]` set writes into that cell the last-read byte as it stood before this read.
- R9: When more than one of `mode[9:6]` is set on a read, the byte written back is the bitwise AND of the enabled sources.
- R10: Every read loads the last-read byte with the data returned, except when `mode[11]` is set, in which case the last-read byte keeps its value.
- R11: If a CPU write targets the same cell in the cycle a write-back is due, the CPU's byte is stored and the write-back is dropped.
- R12: `irq_clr` is high for exactly the cycle after a write whose `wr_data` is 0x00 while `mode[10]` is set, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 8 | Offset of the access within the mirrored window |
| wr_data | input | 8 | CPU write data |
| rd_en | input | 1 | Read strobe, one access per high cycle |
| wr_en | input | 1 | Write strobe, one access per high cycle |
| mode | input | 12 | Access-scrambling mode word |
| rd_data | output | 8 | Registered read data |
| irq_clr | output | 1 | One-cycle request to clear the IRQ latch |

## Verification
The bound checker watches on every cycle that `irq_clr` appears exactly when a qualifying zero-byte write preceded it. It also watches that `rd_data` and the last-read byte move only on a read permitted to change them, and that a write-back is scheduled only by a read with a write-back bit set and carries zero when bit 6 asked for it. The address swizzles, nibble forcing, the contents of address and last-read write-backs, the AND of several sources and the CPU-wins collision only show up in stored contents. The bench therefore shows these by reading cells back, against a byte-level model run through directed cases and a long mixed-mode sweep.

// File: rtl/exram_scrambler.sv
module exram_scrambler #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int MW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [MW-1:0] mode,
  output logic [DW-1:0] rd_data,
  output logic          irq_clr
);
  localparam int DEPTH = 1 << AW;
  localparam int HW    = DW / 2;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] last_rd;
  logic          wb_vld;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_val;

  wire rd_go = rd_en & ~wr_en;

  wire [AW-1:0] ra = cpu_addr ^ {mode[0], {(AW-1){1'b0}}};
  wire [AW-1:0] wa = mode[1] ? {cpu_addr[AW-3:0], cpu_addr[AW-1:AW-2]} : cpu_addr;

  wire [HW-1:0] lo = mode[2] ? '0 : mode[3] ? '1 : wr_data[HW-1:0];
  wire [HW-1:0] hi = mode[4] ? '0 : mode[5] ? '1 : wr_data[DW-1:HW];
  wire [DW-1:0] wd = {hi, lo};

  wire [DW-1:0] wb_next = (mode[6] ? {DW{1'b0}} : {DW{1'b1}})
                        & (mode[8] ? DW'(ra)    : {DW{1'b1}})
                        & (mode[9] ? last_rd    : {DW{1'b1}});
  wire          wb_req  = rd_go & (mode[9:6] != 4'b0);
  wire          wb_hit  = wr_en & (wa == wb_addr);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wa] <= wd;
    if (wb_vld && !wb_hit) mem[wb_addr] <= wb_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      last_rd <= '0;
      wb_vld  <= 1'b0;
      wb_addr <= '0;
      wb_val  <= '0;
      irq_clr <= 1'b0;
    end else begin
      if (rd_go) rd_data <= mem[ra];
      if (rd_go && !mode[11]) last_rd <= mem[ra];
      wb_vld  <= wb_req;
      if (wb_req) begin
        wb_addr <= ra;
        wb_val  <= wb_next;
      end
      irq_clr <= wr_en & mode[10] & (wr_data == '0);
    end
  end
endmodule

// File: rtl/exram_scrambler_chk.sv
module exram_scrambler_chk #(
  parameter int DW = 8,
  parameter int MW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] wr_data,
  input logic          rd_en,
  input logic          wr_en,
  input logic [MW-1:0] mode,
  input logic [DW-1:0] rd_data,
  input logic          irq_clr,
  input logic [DW-1:0] last_rd,
  input logic          wb_vld,
  input logic [DW-1:0] wb_val
);
  // R12
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |-> $past(wr_en && mode[10] && wr_data == '0));

  // R12
  irq_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && mode[10] && wr_data == '0) |-> irq_clr);

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en && !wr_en) |-> $stable(rd_data));

  // R10
  last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en && !wr_en && !mode[11]) |-> $stable(last_rd));

  // R6
  wb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_vld |-> $past(rd_en && !wr_en && mode[9:6] != 4'b0));

  // R6
  wb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_vld && $past(mode[6])) |-> wb_val == '0);
endmodule

bind exram_scrambler exram_scrambler_chk #(.DW(DW), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .rd_en(rd_en), .wr_en(wr_en),
  .mode(mode), .rd_data(rd_data), .irq_clr(irq_clr), .last_rd(last_rd),
  .wb_vld(wb_vld), .wb_val(wb_val)
);

// File: tb/exram_scrambler_bench.sv
module exram_scrambler_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cpu_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] mode = '0;
  logic [7:0]  rd_data;
  logic        irq_clr;

  exram_scrambler u_exram_scrambler (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .wr_data(wr_data),
    .rd_en(rd_en), .wr_en(wr_en), .mode(mode), .rd_data(rd_data), .irq_clr(irq_clr)
  );

  always #10 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [7:0] m_mem [256];
  logic [7:0] m_last = 8'h00;
  logic [7:0] m_rd = 8'h00;
  logic       p_vld = 1'b0;
  logic [7:0] p_addr = '0;
  logic [7:0] p_val = '0;
  logic [31:0] seed = 32'h1234_5677;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input bit rd, input bit wr,
                     input logic [7:0] a, input logic [7:0] d, input logic [11:0] m);
    logic [7:0] ea_r, ea_w, wd, v;
    logic       exp_irq, go;
    rd_en = rd; wr_en = wr; cpu_addr = a; wr_data = d; mode = m;
    ea_r = a ^ {m[0], 7'b0};
    ea_w = m[1] ? {a[5:0], a[7:6]} : a;
    wd[3:0] = m[2] ? 4'h0 : m[3] ? 4'hF : d[3:0];
    wd[7:4] = m[4] ? 4'h0 : m[5] ? 4'hF : d[7:4];
    go = rd && !wr;
    exp_irq = wr && m[10] && d == 8'h00;
    v = 8'hFF;
    if (m[6]) v = v & 8'h00;
    if (m[8]) v = v & ea_r;
    if (m[9]) v = v & m_last;
    if (go) m_rd = m_mem[ea_r];
    if (go && !m[11]) m_last = m_mem[ea_r];
    if (p_vld && !(wr && ea_w == p_addr)) m_mem[p_addr] = p_val;
    if (wr) m_mem[ea_w] = wd;
    p_vld = go && (m[9:6] != 4'b0);
    if (p_vld) begin p_addr = ea_r; p_val = v; end
    @(posedge clk);
    #5;
    if (go) check(tag, rd_data, m_rd);
    check("R12 irq", {7'b0, irq_clr}, {7'b0, exp_irq});
    @(negedge clk);
    rd_en = 0; wr_en = 0;
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [7:0] d, input logic [11:0] m);
    cyc(tag, 0, 1, a, d, m);
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [11:0] m);
    cyc(tag, 1, 0, a, 8'h00, m);
  endtask

  task automatic idle();
    cyc("idle", 0, 0, 8'h00, 8'h00, 12'h000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset rd_data", rd_data, 8'h00);
    check("R1 reset irq_clr", {7'b0, irq_clr}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: last-read byte is 0 after reset, seen through a bit9 write-back
    wr("init", 8'h20, 8'hF7, 12'h000);
    rd("R1 last-read reset", 8'h20, 12'h200);
    idle();
    rd("R1 last-read reset wb", 8'h20, 12'h000);
    check("R1 last-read reset direct", rd_data, 8'h00);

    for (int i = 0; i < 256; i++) wr("init", 8'(i), 8'(i) ^ 8'h5A, 12'h000);
    // R2: sweep all cells back
    for (int i = 0; i < 256; i++) rd("R2 read back", 8'(i), 12'h000);
    cyc("R2 rd+wr write wins", 1, 1, 8'h33, 8'hC3, 12'h000);
    idle();
    check("R2 rd ignored holds data", rd_data, 8'hFF ^ 8'h5A);
    rd("R2 rd+wr stored", 8'h33, 12'h000);

    // R3
    rd("R3 toggle bit7", 8'h05, 12'h001);
    check("R3 direct", rd_data, 8'h85 ^ 8'h5A);
    wr("R3 write unaffected", 8'h10, 8'hA1, 12'h001);
    rd("R3 write unaffected", 8'h10, 12'h000);
    check("R3 direct write", rd_data, 8'hA1);

    // R4
    wr("R4 rotate", 8'h41, 8'h3C, 12'h002);
    rd("R4 rotate", 8'h05, 12'h000);
    check("R4 direct", rd_data, 8'h3C);
    rd("R4 read unrotated", 8'h41, 12'h002);

    // R5
    for (int k = 0; k < 16; k++) begin
      wr("R5 force", 8'h60 + 8'(k), 8'h96, {6'b0, 4'(k), 2'b0});
      rd("R5 force", 8'h60 + 8'(k), 12'h000);
    end
    wr("R5 conflict", 8'h71, 8'hB7, 12'h03C);
    rd("R5 conflict", 8'h71, 12'h000);
    check("R5 conflict direct", rd_data, 8'h00);

    // R6, R7, R8, R9, R10
    for (int k = 1; k < 32; k++) begin
      rd("R6 R7 R8 R9 wb trigger", 8'h80 + 8'(k), {1'b0, 1'b0, 5'(k)} << 6 | 12'(k[4] ? 12'h800 : 12'h0));
      idle();
      rd("R6 R7 R8 R9 wb result", 8'h80 + 8'(k), 12'h000);
    end
    rd("R6 bit7", 8'h90, 12'h080);
    idle();
    rd("R6 bit7 result", 8'h90, 12'h000);
    check("R6 bit7 direct", rd_data, 8'hFF);
    rd("R7 addr", 8'h11, 12'h101);
    idle();
    rd("R7 addr result", 8'h91, 12'h000);
    check("R7 direct", rd_data, 8'h91);
    rd("R10 freeze", 8'h22, 12'h800);
    rd("R8 prev", 8'h23, 12'h200);
    idle();
    rd("R8 prev result", 8'h23, 12'h000);

    // R11
    rd("R11 collide", 8'h44, 12'h040);
    wr("R11 collide", 8'h44, 8'h5E, 12'h000);
    rd("R11 cpu wins", 8'h44, 12'h000);
    check("R11 direct", rd_data, 8'h5E);

    // R12
    wr("R12 zero", 8'h50, 8'h00, 12'h400);
    wr("R12 nonzero", 8'h50, 8'h01, 12'h400);
    wr("R12 off", 8'h50, 8'h00, 12'h000);
    wr("R12 forced", 8'h50, 8'hF0, 12'h410);

    // mixed-mode sweep over a 64-cell region
    for (int n = 0; n < 6000; n++) begin
      logic [7:0] a;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      a = {seed[0], seed[1], 2'b00, seed[5:2]};
      case (seed[7:6])
        2'd0, 2'd1: rd("R2 R3 R6 R7 R8 R9 R10 sweep", a, seed[19:8]);
        2'd2: wr("R4 R5 sweep", a, seed[27:20] & {8{seed[28]}}, seed[19:8]);
        default: cyc("R2 R11 sweep", seed[29], seed[30], a, seed[27:20], seed[19:8]);
      endcase
    end
    idle();
    for (int i = 0; i < 256; i++) rd("R11 final sweep", 8'(i), 12'h000);

    finish_run();
  end
endmodule